// File: doc/BRIEF.md
# Program Counter and Link Sequencer

This block owns the instruction fetch address of a processor front end. On every clock edge it decides the address of the next fetch. It can keep the current address, step to the next sequential instruction, jump to a branch target, make a subroutine call that also sends the return address to the link register, or return by reloading the fetch address from the link register's current value.

A mode input picks the instruction width: the full instruction set has 4-byte instructions and the compact set has 2-byte instructions. The sequential step and the address alignment both follow this input. Decode, condition evaluation, the register file and the instruction memory live outside. The surrounding logic supplies one-cycle request strobes, a target address and the link register's contents. It takes back the fetch address and a registered write port into the link register.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next `fetch_addr` is `START_ADDR` (default 0x0000_0100) and `lr_we` is 0.
- R2: With `compact`=0, `adv`=1 and no branch, call or return request, `fetch_addr` increases by 4 at the edge.
- R3: With `compact`=1, `adv`=1 and no branch, call or return request, `fetch_addr` increases by 2 at the edge.
- R4: A branch request (`br_req`=1) with no call or return request loads the aligned `tgt_addr` into `fetch_addr` at the edge.
- R5: A call request (`call_req`=1) with no return request loads the aligned `tgt_addr` into `fetch_addr`. In the same edge it sets `lr_we`=1 with `lr_wdata` equal to the aligned address of the instruction after the call, which is the old `fetch_addr` plus the step of R2/R3.
- R6: A return request (`ret_req`=1) loads the aligned `lr_rd` into `fetch_addr` at the edge.
- R7: Every address that is loaded is aligned using the `compact` value sampled at that edge. Bit 0 is cleared always. Bit 1 is also cleared when `compact`=0.
- R8: Requests are served in a fixed order: return wins over call, call wins over branch, and branch wins over a sequential step.
- R9: With no request and `adv`=0, `fetch_addr` holds its value. `lr_we` is 1 only in the cycle after an edge that served a call, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Step to the next sequential instruction |
| compact | input | 1 | Instruction-set state: 1 selects 2-byte instructions, 0 selects 4-byte instructions |
| br_req | input | 1 | Taken branch to `tgt_addr` |
| call_req | input | 1 | Subroutine call to `tgt_addr`, saving the return address |
| ret_req | input | 1 | Return to the address held in the link register |
| tgt_addr | input | ADDR_W | Branch or call target |
| lr_rd | input | ADDR_W | Current link register contents |
| fetch_addr | output | ADDR_W | Registered instruction fetch address |
| lr_we | output | 1 | Registered link register write strobe |
| lr_wdata | output | ADDR_W | Registered return address to be written to the link register |

## Verification
Sequential runs are tried in both modes and across a mode switch from compact to full at an address with bit 1 set. This shows that the step size and the alignment each follow the mode input. Branch, call and return are each given misaligned targets in both modes, which separates correct masking from a plain load. Requests are then combined (all three together, call with branch, branch with a step) so that the priority order is told apart from any other ordering. Idle cycles between operations show that the address holds and that the link strobe stays low. A reset in the middle of the run checks that the start address is restored.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } pc_op_e;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
  import pcseq_pkg::*;
(
  input  logic   adv,
  input  logic   br_req,
  input  logic   call_req,
  input  logic   ret_req,
  output pc_op_e op
);
  always_comb begin
    if (ret_req)       op = OP_RET;
    else if (call_req) op = OP_CALL;
    else if (br_req)   op = OP_JUMP;
    else if (adv)      op = OP_STEP;
    else               op = OP_HOLD;
  end

  // R8: a higher-ranked request must never lose to a lower-ranked one
  always_comb begin
    if (ret_req) begin
      assert_ret_wins_R8: assert (op == OP_RET);
    end
    if (call_req && !ret_req) begin
      assert_call_wins_R8: assert (op == OP_CALL);
    end
  end
endmodule

// File: rtl/pcseq_nextpc.sv
module pcseq_nextpc
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  pc_op_e            op,
  input  logic              compact,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] lr_rd,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam logic [ADDR_W-1:0] STEP_FULL    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_COMPACT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] MASK_FULL    = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] MASK_COMPACT = ~ADDR_W'(1);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] mask;

  assign step   = compact ? STEP_COMPACT : STEP_FULL;
  assign mask   = compact ? MASK_COMPACT : MASK_FULL;
  assign seq_pc = (pc + step) & mask;

  always_comb begin
    unique case (op)
      OP_STEP: next_pc = seq_pc;
      OP_JUMP: next_pc = tgt_addr & mask;
      OP_CALL: next_pc = tgt_addr & mask;
      OP_RET:  next_pc = lr_rd & mask;
      default: next_pc = pc;
    endcase
  end

  // R7: the chosen address never carries an odd byte offset
  always_comb begin
    assert_next_even_R7: assert (op == OP_HOLD || next_pc[0] == 1'b0);
  end
endmodule

// File: rtl/pcseq_link.sv
module pcseq_link
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_op_e            op,
  input  logic [ADDR_W-1:0] seq_pc,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lr_we    <= 1'b0;
      lr_wdata <= '0;
    end else begin
      lr_we <= (op == OP_CALL);
      if (op == OP_CALL) lr_wdata <= seq_pc;
    end
  end

  // R9: the strobe only follows a served call
  assert_we_after_call_R9: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> ($past(op) == OP_CALL));

  // R5: a served call always raises the strobe with the return address
  assert_call_writes_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CALL) |=> (lr_we && lr_wdata == $past(seq_pc)));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              compact,
  input  logic              br_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] lr_rd,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_wdata
);
  localparam logic [ADDR_W-1:0] LOW1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LOW3 = ADDR_W'(3);

  pc_op_e            op;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] seq_pc;

  pcseq_arbiter u_arb (
    .adv      (adv),
    .br_req   (br_req),
    .call_req (call_req),
    .ret_req  (ret_req),
    .op       (op)
  );

  pcseq_nextpc #(.ADDR_W(ADDR_W)) u_next (
    .pc       (fetch_addr),
    .op       (op),
    .compact  (compact),
    .tgt_addr (tgt_addr),
    .lr_rd    (lr_rd),
    .next_pc  (next_pc),
    .seq_pc   (seq_pc)
  );

  pcseq_link #(.ADDR_W(ADDR_W)) u_link (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .seq_pc   (seq_pc),
    .lr_we    (lr_we),
    .lr_wdata (lr_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) fetch_addr <= START_ADDR;
    else     fetch_addr <= next_pc;
  end

  // R1: reset restores the start address and clears the strobe
  assert_reset_start_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == START_ADDR && !lr_we));

  // R6: a return reloads the aligned link value
  assert_return_load_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ret_req)) |->
      fetch_addr == ($past(compact) ? ($past(lr_rd) & ~LOW1)
                                    : ($past(lr_rd) & ~LOW3)));

  // R9: with nothing requested the address holds
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv) && !$past(br_req) && !$past(call_req) && !$past(ret_req))
      |-> ($stable(fetch_addr) && !lr_we));

  // R4: an unopposed branch lands on the aligned target
  assert_branch_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_req) && !$past(call_req) && !$past(ret_req)) |->
      fetch_addr == ($past(compact) ? ($past(tgt_addr) & ~LOW1)
                                    : ($past(tgt_addr) & ~LOW3)));
endmodule

// File: tb/test_pcseq_top.sv
`timescale 1ns/1ps
module test_pcseq_top;
  localparam int          AW    = 32;
  localparam logic [31:0] START = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv = 1'b0, compact = 1'b0;
  logic          br_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] tgt_addr = '0, lr_rd = '0;
  logic [AW-1:0] fetch_addr, lr_wdata;
  logic          lr_we;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  // model state
  logic [31:0] m_pc   = START;
  logic        m_we   = 1'b0;
  logic [31:0] m_data = '0;

  always #4 clk = ~clk;

  pcseq_top #(.ADDR_W(AW), .START_ADDR(START)) i_pcseq_top (
    .clk(clk), .rst(rst), .adv(adv), .compact(compact),
    .br_req(br_req), .call_req(call_req), .ret_req(ret_req),
    .tgt_addr(tgt_addr), .lr_rd(lr_rd),
    .fetch_addr(fetch_addr), .lr_we(lr_we), .lr_wdata(lr_wdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] fit(input logic [31:0] a, input logic c);
    return c ? (a & ~32'd1) : (a & ~32'd3);
  endfunction

  task automatic check(input string req);
    n_run++;
    if (fetch_addr !== m_pc) begin
      n_fail++;
      $display("FAIL %s fetch_addr: actual %h, expected %h", req, fetch_addr, m_pc);
    end
    if (lr_we !== m_we) begin
      n_fail++;
      $display("FAIL %s lr_we: actual %b, expected %b", req, lr_we, m_we);
    end
    if (m_we && lr_wdata !== m_data) begin
      n_fail++;
      $display("FAIL %s lr_wdata: actual %h, expected %h", req, lr_wdata, m_data);
    end
  endtask

  // drive at negedge, model at posedge, compare at the following negedge
  task automatic cyc(input string req, input logic r, input logic a, input logic c,
                     input logic b, input logic cl, input logic rt,
                     input logic [31:0] t, input logic [31:0] l);
    rst = r; adv = a; compact = c; br_req = b; call_req = cl; ret_req = rt;
    tgt_addr = t; lr_rd = l;
    @(posedge clk);
    if (r) begin
      m_pc = START; m_we = 1'b0;
    end else if (rt) begin
      m_pc = fit(l, c); m_we = 1'b0;
    end else if (cl) begin
      m_data = fit(m_pc + (c ? 32'd2 : 32'd4), c);
      m_pc = fit(t, c); m_we = 1'b1;
    end else if (b) begin
      m_pc = fit(t, c); m_we = 1'b0;
    end else if (a) begin
      m_pc = fit(m_pc + (c ? 32'd2 : 32'd4), c); m_we = 1'b0;
    end else begin
      m_we = 1'b0;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    @(negedge clk);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 1, 1, 0, 1, 0, 0, 32'h9000, 0);
    for (int i = 0; i < 3; i++) cyc("R2", 0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 1, 1, 0, 0, 0, 0, 0);
    cyc("R7", 0, 1, 0, 0, 0, 0, 0, 0);              // 0x112 -> 0x114
    for (int i = 0; i < 2; i++) cyc("R9", 0, 0, 1, 0, 0, 0, 32'hFFFF, 32'hEEEE);
    cyc("R4", 0, 0, 0, 1, 0, 0, 32'h0000_2003, 0);  // -> 0x2000
    cyc("R4", 0, 0, 1, 1, 0, 0, 32'h0000_3007, 0);  // -> 0x3006
    cyc("R5", 0, 0, 1, 0, 1, 0, 32'h0000_4000, 0);  // link 0x3008
    cyc("R9", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R5", 0, 1, 0, 0, 1, 0, 32'h0000_6002, 0);  // -> 0x6000, link 0x4004
    cyc("R6", 0, 0, 1, 0, 0, 1, 0, 32'h0000_5001);  // -> 0x5000
    cyc("R6", 0, 1, 0, 0, 0, 1, 0, 32'h0000_5006);  // -> 0x5004
    cyc("R8", 0, 1, 0, 1, 1, 1, 32'h0000_7000, 32'h0000_8000);
    cyc("R8", 0, 1, 0, 1, 1, 0, 32'h0000_7100, 32'h0000_8000);
    cyc("R8", 0, 1, 1, 1, 0, 0, 32'h0000_7201, 0);
    cyc("R3", 0, 1, 1, 0, 0, 0, 0, 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 0, 1, 0, 0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule